// File: doc/BRIEF.md
# Sixteen-Bit Modulo Timer Counter with Byte-Coherent Access

This block is a 16-bit timer counter placed behind an 8-bit register bus. It advances by one step on each cycle where the count-enable tick is high, and it wraps or turns around at a programmable modulo limit. There are two counting modes. The first is a plain up-counter that wraps to zero. The second is a center-aligned up/down counter that reverses direction at the limit and again at zero. Each time the counter reaches the limit it raises an overflow flag, and the flag can request an interrupt.

The CPU side reads and writes the block one byte at a time. Reading the counter's upper byte captures the lower byte, so the two halves of a read always belong together. The modulo limit is written as two bytes and takes effect as one 16-bit value once both bytes have arrived. While the pair is incomplete, setting of the overflow flag is blocked. A debug-halt input stops the counter and freezes the read-capture state.

Register map, addressed on `busAddr`: 0 is the status/control byte, 1 is the counter upper byte, 2 is the counter lower byte, 3 is the modulo upper byte and 4 is the modulo lower byte. Every other address reads as 0x00 and ignores writes. Reads are combinational in the same cycle as `busRd`. Writes take effect at the clock edge that samples `busWr`.

Top module: `mod_counter16`

## Requirements
- R1: With mode bit (status bit 5) at 0, a counting step taken while the counter equals the limit loads 0x0000 and sets the overflow flag (status bit 7). Any other step adds one, modulo 2^16.
- R2: With mode bit 1 and the direction up, a step taken at the limit reverses the direction to down, loads limit−1 and sets the overflow flag.
- R3: With mode bit 1 and the direction down, a step taken at 0x0000 turns the direction back to up and loads 0x0001, and the overflow flag is not set. Any other down step subtracts one.
- R4: A write to address 3 or address 4 is held in a buffer. The 16-bit limit (address 3 holds bits 15:8, address 4 holds bits 7:0) changes only when both bytes have been written, in either order. Until then, comparisons and modulo reads use the previous complete value, and the overflow flag cannot be set.
- R5: After reset every readable byte is 0x00. A limit of 0x0000 means the counter runs freely, so it reaches 0xFFFF before wrapping.
- R6: Reading address 1 returns the counter's upper byte and captures the lower byte. The next read of address 2 returns the captured byte and releases the capture. Without a capture, address 2 returns the live lower byte.
- R7: While `dbgHalt` is 1, the counter does not step and the capture state does not change, even when addresses 1 or 2 are read.
- R8: The overflow flag clears only when status is first read while the flag is 1 and status is then written with bit 7 at 0. A status write that has no such read before it leaves the flag unchanged. Status bits 6 and 5 are written directly.
- R9: `irq` is 1 exactly when the overflow flag and the interrupt enable (status bit 6) are both 1.
- R10: Any write to address 1 or address 2 loads 0x0000 into the counter, sets the direction to up and releases the capture.
- R11: The counter steps only in cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; read side effects occur at the clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from the address |
| tick | input | 1 | Count enable for one step |
| dbgHalt | input | 1 | Debug halt; freezes the counter and the capture state |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due in the same cycle as the strobe, so the bench drives its inputs after the falling edge and samples one time unit later, before the rising edge. A counting step, a register write, a flag set and a capture all land at the next rising edge, and `irq` follows the flag in that same cycle. For this reason the behavioural model in the bench advances exactly once per rising edge and is compared against `irq` on every cycle and against the read data on every read. Directed sequences place the wrap point, the two turning points, a split modulo write and halted reads on known cycles. A long free-running stretch and a random phase follow them.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_MOD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_MOD_LO = 3'd4;

  // Status bit positions
  localparam int B_FLAG = 7;
  localparam int B_IEN  = 6;
  localparam int B_MODE = 5;

  typedef struct packed {
    logic cntClear;
    logic step;
    logic centerMode;
    logic modCommit;
  } mc16Strobes_t;
endpackage

// File: rtl/mc16_datapath.sv
module mc16_datapath
  import mc16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  mc16Strobes_t     strb,
  input  logic [CNT_W-1:0] modNew,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] modVal,
  output logic             turnEvt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dirDown;
  logic [CNT_W-1:0] limitVal;
  logic             atLimit;
  logic             atZero;

  always_comb begin
    limitVal = (modVal == '0) ? '1 : modVal;
    atLimit  = (cnt == limitVal);
    atZero   = (cnt == '0);
    turnEvt  = strb.step && !strb.cntClear && atLimit &&
               (!strb.centerMode || !dirDown);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dirDown <= 1'b0;
    end else if (strb.cntClear) begin
      cnt     <= '0;
      dirDown <= 1'b0;
    end else if (strb.step) begin
      if (!strb.centerMode) begin
        dirDown <= 1'b0;
        cnt     <= atLimit ? '0 : cnt + ONE;
      end else if (!dirDown) begin
        if (atLimit) begin
          dirDown <= 1'b1;
          cnt     <= cnt - ONE;
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        if (atZero) begin
          dirDown <= 1'b0;
          cnt     <= ONE;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               modVal <= '0;
    else if (strb.modCommit) modVal <= modNew;
  end

  // R1: an up-mode step at the limit lands on zero
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.cntClear && !strb.centerMode && atLimit) |=> (cnt == '0));

  // R2: center mode reverses at the limit
  assert_center_turn_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.cntClear && strb.centerMode && !dirDown && atLimit)
      |=> (dirDown && cnt == $past(limitVal) - ONE));

  // R3: center mode turns up again at zero
  assert_center_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.cntClear && strb.centerMode && dirDown && atZero)
      |=> (!dirDown && cnt == ONE));

  // R7: no step while halted (the halt gates step in the control)
  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.cntClear) |=> $stable(cnt));

  // R10: counter write clears count and direction
  assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClear |=> (cnt == '0 && !dirDown));
endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              tick,
  input  logic              dbgHalt,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  modVal,
  input  logic              turnEvt,
  output mc16Strobes_t      strb,
  output logic [CNT_W-1:0]  modNew,
  output logic              irq
);
  logic ovfFlag, irqEn, centerSel, clearArm;
  logic gotHi, gotLo, modPending;
  logic [DATA_W-1:0] hiBuf, loBuf, nextHi, nextLo, loLatch;
  logic cntLatched;
  logic wrStat, rdStat, wrModHi, wrModLo, rdCntHi, rdCntLo, setOvf, clrOvf;

  always_comb begin
    wrStat  = busWr && (busAddr == A_STAT);
    rdStat  = busRd && (busAddr == A_STAT);
    wrModHi = busWr && (busAddr == A_MOD_HI);
    wrModLo = busWr && (busAddr == A_MOD_LO);
    rdCntHi = busRd && (busAddr == A_CNT_HI);
    rdCntLo = busRd && (busAddr == A_CNT_LO);
    modPending = gotHi || gotLo;
    nextHi = wrModHi ? busWrData : hiBuf;
    nextLo = wrModLo ? busWrData : loBuf;
    modNew = {nextHi, nextLo};
    strb.cntClear   = busWr && (busAddr == A_CNT_HI || busAddr == A_CNT_LO);
    strb.step       = tick && !dbgHalt;
    strb.centerMode = centerSel;
    strb.modCommit  = (wrModHi || wrModLo) && (gotHi || wrModHi) && (gotLo || wrModLo);
    setOvf = turnEvt && !modPending;
    clrOvf = wrStat && clearArm && !busWrData[B_FLAG];
    irq    = ovfFlag && irqEn;
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      A_STAT: begin
        busRdData[B_FLAG] = ovfFlag;
        busRdData[B_IEN]  = irqEn;
        busRdData[B_MODE] = centerSel;
      end
      A_CNT_HI: busRdData = cnt[CNT_W-1:DATA_W];
      A_CNT_LO: busRdData = cntLatched ? loLatch : cnt[DATA_W-1:0];
      A_MOD_HI: busRdData = modVal[CNT_W-1:DATA_W];
      A_MOD_LO: busRdData = modVal[DATA_W-1:0];
      default:  busRdData = '0;
    endcase
  end

  // Status, flag and clear sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag   <= 1'b0;
      irqEn     <= 1'b0;
      centerSel <= 1'b0;
      clearArm  <= 1'b0;
    end else begin
      if (setOvf)      ovfFlag <= 1'b1;
      else if (clrOvf) ovfFlag <= 1'b0;
      if (wrStat)                clearArm <= 1'b0;
      else if (rdStat && ovfFlag) clearArm <= 1'b1;
      if (wrStat) begin
        irqEn     <= busWrData[B_IEN];
        centerSel <= busWrData[B_MODE];
      end
    end
  end

  // Modulo byte pairing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiBuf <= '0;
      loBuf <= '0;
      gotHi <= 1'b0;
      gotLo <= 1'b0;
    end else begin
      hiBuf <= nextHi;
      loBuf <= nextLo;
      if (strb.modCommit) begin
        gotHi <= 1'b0;
        gotLo <= 1'b0;
      end else begin
        if (wrModHi) gotHi <= 1'b1;
        if (wrModLo) gotLo <= 1'b1;
      end
    end
  end

  // Counter read capture, frozen during halt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLatched <= 1'b0;
      loLatch    <= '0;
    end else if (!dbgHalt) begin
      if (strb.cntClear) begin
        cntLatched <= 1'b0;
      end else if (rdCntHi) begin
        cntLatched <= 1'b1;
        loLatch    <= cnt[DATA_W-1:0];
      end else if (rdCntLo) begin
        cntLatched <= 1'b0;
      end
    end
  end

  // R4: no flag set while a modulo pair is incomplete
  assert_flag_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfFlag && modPending) |=> !ovfFlag);

  // R7: capture state frozen while halted
  assert_latch_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    dbgHalt |=> ($stable(cntLatched) && $stable(loLatch)));

  // R8: flag clears only after an armed status write
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(wrStat && clearArm)) |=> ovfFlag);

  // R11: halted or idle cycles never step
  assert_step_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!tick || dbgHalt) |-> !strb.step);
endmodule

// File: rtl/mod_counter16.sv
module mod_counter16
  import mc16_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              tick,
  input  logic              dbgHalt,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  mc16Strobes_t     strb;
  logic [CNT_W-1:0] cnt, modVal, modNew;
  logic             turnEvt;

  mc16_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .tick(tick), .dbgHalt(dbgHalt),
    .cnt(cnt), .modVal(modVal), .turnEvt(turnEvt), .strb(strb), .modNew(modNew),
    .irq(irq)
  );

  mc16_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .modNew(modNew), .cnt(cnt),
    .modVal(modVal), .turnEvt(turnEvt)
  );
endmodule

// File: tb/mod_counter16_bench.sv
module mod_counter16_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0, tick = 1'b0, dbgHalt = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic irq;

  always #5 clk = ~clk;

  mod_counter16 u_mod_counter16 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .tick(tick),
    .dbgHalt(dbgHalt), .irq(irq)
  );

  int nChk = 0, nBad = 0;
  int mCnt = 0, mDir = 0, mMod = 0, mHi = 0, mLo = 0, mGh = 0, mGl = 0;
  int mFlag = 0, mIe = 0, mCms = 0, mArm = 0, mLat = 0, mLatV = 0;
  int lastRd = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int expRead(input int a);
    case (a)
      0: return (mFlag << 7) | (mIe << 6) | (mCms << 5);
      1: return mCnt >> 8;
      2: return mLat ? mLatV : (mCnt & 255);
      3: return mMod >> 8;
      4: return mMod & 255;
      default: return 0;
    endcase
  endfunction

  function automatic string tagFor(input int a);
    case (a)
      0: return "R8";
      1, 2: return "R6";
      3, 4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic modelStep(input int a, input bit w, input bit r, input int d,
                           input bit t, input bit h);
    int limit = (mMod == 0) ? 65535 : mMod;
    bit clr = w && (a == 1 || a == 2);
    bit evt = 0;
    int nCnt = mCnt, nDir = mDir, nFlag = mFlag, nArm = mArm;
    if (clr) begin nCnt = 0; nDir = 0; end
    else if (t && !h) begin
      if (!mCms) begin
        nDir = 0;
        if (mCnt == limit) begin nCnt = 0; evt = 1; end
        else nCnt = (mCnt + 1) & 16'hFFFF;
      end else if (mDir == 0) begin
        if (mCnt == limit) begin nDir = 1; nCnt = mCnt - 1; evt = 1; end
        else nCnt = (mCnt + 1) & 16'hFFFF;
      end else begin
        if (mCnt == 0) begin nDir = 0; nCnt = 1; end
        else nCnt = mCnt - 1;
      end
    end
    if (w && a == 0 && mArm != 0 && d[7] == 1'b0) nFlag = 0;
    if (evt && mGh == 0 && mGl == 0) nFlag = 1;
    if (w && a == 0) nArm = 0;
    else if (r && a == 0 && mFlag != 0) nArm = 1;
    if (w && a == 0) begin mIe = d[6]; mCms = d[5]; end
    if (!h) begin
      if (clr) mLat = 0;
      else if (r && a == 1) begin mLat = 1; mLatV = mCnt & 255; end
      else if (r && a == 2) mLat = 0;
    end
    if (w && a == 3) begin mHi = d; mGh = 1; end
    if (w && a == 4) begin mLo = d; mGl = 1; end
    if (w && (a == 3 || a == 4) && mGh != 0 && mGl != 0) begin
      mMod = (mHi << 8) | mLo; mGh = 0; mGl = 0;
    end
    mCnt = nCnt; mDir = nDir; mFlag = nFlag; mArm = nArm;
  endtask

  task automatic cyc(input int a, input bit w, input bit r, input int d,
                     input bit t, input bit h);
    busAddr = 3'(a); busWr = w; busRd = r; busWrData = 8'(d);
    tick = t; dbgHalt = h;
    #1;
    chk("R9", int'(irq), (mFlag & mIe));
    lastRd = int'(busRdData);
    if (r) chk(tagFor(a), lastRd, expRead(a));
    modelStep(a, w, r, d, t, h);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d); cyc(a, 1, 0, d, 0, 0); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0);
  endtask
  task automatic rdx(input int a, input int exp, input string tag);
    cyc(a, 0, 1, 0, 0, 0);
    chk(tag, lastRd, exp);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5 reset state
    for (int a = 0; a < 6; a++) rdx(a, 0, "R5");
    chk("R5", int'(irq), 0);

    // R4 split modulo write, low byte first
    wr(0, 8'h40);
    wr(4, 3);
    rdx(4, 0, "R4");
    wr(3, 0);
    rdx(4, 3, "R4");

    // R1 wrap at limit 3
    wr(1, 0);
    ticks(3);
    rdx(2, 3, "R1");
    ticks(1);
    rdx(2, 0, "R1");
    rdx(0, 8'hC0, "R1");
    chk("R9", int'(irq), 1);
    wr(0, 8'h40);
    rdx(0, 8'h40, "R8");

    // R8 write without prior read does nothing
    ticks(4);
    wr(0, 8'h40);
    rdx(0, 8'hC0, "R8");
    wr(0, 8'h40);
    rdx(0, 8'h40, "R8");

    // R4 flag blocked while pending
    wr(3, 0);
    ticks(4);
    rdx(0, 8'h40, "R4");
    wr(4, 5);
    rdx(4, 5, "R4");

    // R2 / R3 center-aligned
    wr(0, 8'h60);
    wr(1, 0);
    ticks(5);
    rdx(2, 5, "R2");
    ticks(1);
    rdx(2, 4, "R2");
    rdx(0, 8'hE0, "R2");
    ticks(4);
    rdx(2, 0, "R3");
    ticks(1);
    rdx(2, 1, "R3");

    // R6 coherent read
    rdx(1, 0, "R6");
    ticks(2);
    rdx(2, 1, "R6");
    rdx(2, 3, "R6");

    // R7 halt freeze
    rdx(1, 0, "R7");
    ticks(1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 1);
    cyc(2, 0, 1, 0, 1, 1); chk("R7", lastRd, 3);
    cyc(2, 0, 1, 0, 1, 1); chk("R7", lastRd, 3);
    cyc(1, 0, 1, 0, 1, 1);
    rdx(2, 3, "R7");
    rdx(2, 4, "R7");

    // R10 counter write resets direction
    ticks(1);
    ticks(1);
    rdx(2, 4, "R10");
    cyc(2, 1, 0, 8'h77, 0, 0);
    rdx(2, 0, "R10");
    ticks(1);
    rdx(2, 1, "R10");

    // R11 no step without tick
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0);
    rdx(2, 1, "R11");

    // R5 free run across full range
    rdx(0, 8'hE0, "R8");
    wr(0, 8'h00);
    wr(3, 0); wr(4, 0);
    wr(1, 0);
    ticks(65535);
    rdx(1, 8'hFF, "R5");
    rdx(2, 8'hFF, "R5");
    ticks(1);
    rdx(1, 0, "R1");
    rdx(0, 8'h80, "R1");

    // random phase, compared against the model every cycle
    wr(3, 0); wr(4, 9);
    for (int i = 0; i < 4000; i++) begin
      int a = $urandom % 6;
      bit w = ($urandom % 8) == 0;
      bit r = !w && (($urandom % 3) == 0);
      int d = $urandom % 256;
      if (a == 3) d = 0;
      if (a == 4) d = 2 + ($urandom % 12);
      if (w && (a == 1 || a == 2) && ($urandom % 4) != 0) w = 0;
      cyc(a, w, r, d, ($urandom % 4) != 0, ($urandom % 16) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule